// File: doc/BRIEF.md
# Write Enable and Protection Controller

This block rules on every request to change non-volatile contents. It owns a one-shot write-enable flag, a lock bit that can freeze the configuration, and a two-bit zone code that marks an upper slice of the 32 KiB byte array as read-only. The active-low write-protect pin is brought into the clock domain through a short synchronizer. The pin and the lock bit together decide whether the configuration may change.

The serial front end raises one-cycle strobes. Some strobes set or clear the enable flag. The others report that an array write or a configuration write has been completed, and an array write also carries its byte address. Each completion strobe is answered in the same cycle by a grant. A granted request consumes the enable flag. A refused request leaves every bit untouched. A status byte reports the flag, the zone code and the lock bit, and carries an external busy indication.

Top module: `wpc_ctrl`

## Requirements
- R1: A pulse on `we_set_i` sets the write-enable flag at the next clock edge. The flag reads back on `status_o[1]`.
- R2: The flag is cleared at the next edge by each of these: a `we_clr_i` pulse, a granted array write, a granted configuration write.
- R3: `arr_grant_o` is high in the cycle of `arr_wr_i` only when the flag is set and the address lies outside the protected zone.
- R4: With a 15-bit address, the zone code on `status_o[3:2]` protects the following addresses. Code 00 protects nothing. Code 01 protects 0x6000 to 0x7FFF. Code 10 protects 0x4000 to 0x7FFF. Code 11 protects the whole array.
- R5: A granted configuration write loads the lock bit from `cfg_data_i[7]` and the zone code from `cfg_data_i[3:2]`. All other data bits are ignored.
- R6: Hardware lock (`hw_locked_o`) holds when the lock bit is 1 and the synchronized pin is 0. It refuses every configuration write. A pin change reaches `hw_locked_o` after two clock edges.
- R7: When the lock bit is 0, or the pin is 1, a configuration write is granted whenever the flag is set.
- R8: A refused array write or refused configuration write changes no state. In particular it leaves the flag set.
- R9: `status_o` is laid out as {lock, 000, zone[1:0], flag, `busy_i`}. Bit 0 follows `busy_i` combinationally.
- R10: A low `arst_n` clears the flag, the zone code and the lock bit at once. Strobes have no effect until the second clock edge after `arst_n` returns high.
- R11: When a set strobe and a clearing event fall in the same cycle, the clear wins. An array write and a configuration write in the same cycle are both judged on the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset (power-on) |
| wp_n_i | input | 1 | Write-protect pin, low means protect |
| busy_i | input | 1 | External write-in-progress indication |
| we_set_i | input | 1 | Set-enable strobe |
| we_clr_i | input | 1 | Clear-enable strobe |
| arr_wr_i | input | 1 | Array write completion request |
| arr_addr_i | input | 15 | Byte address of the array write |
| cfg_wr_i | input | 1 | Configuration write completion request |
| cfg_data_i | input | 8 | Byte offered for the configuration |
| arr_grant_o | output | 1 | Array write permitted |
| cfg_grant_o | output | 1 | Configuration write permitted |
| hw_locked_o | output | 1 | Hardware lock active |
| status_o | output | 8 | Status byte |

## Verification
Several events can land on the same clock edge: a set strobe can arrive with a clear strobe or with a granted completion, and an array write can arrive with a configuration write. The bench drives these pairs together deliberately. It checks that the flag ends cleared. It also checks that both grants follow the zone code and lock bit held before that edge, not the values being loaded. A behavioural reference model, updated every clock, supplies the expected grants and status byte for every cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int STAT_W    = 8;
  localparam int ZONE_W    = 2;
  localparam int BUSY_BIT  = 0;
  localparam int WE_BIT    = 1;
  localparam int ZONE_LSB  = 2;
  localparam int LOCK_BIT  = 7;

  typedef enum logic [ZONE_W-1:0] {
    ZONE_NONE    = 2'b00,
    ZONE_QUARTER = 2'b01,
    ZONE_HALF    = 2'b10,
    ZONE_ALL     = 2'b11
  } wpc_zone_e;

  typedef struct packed {
    logic              lock;
    logic [ZONE_W-1:0] zone;
  } wpc_cfg_t;
endpackage

// File: rtl/wpc_rst_sync.sv
module wpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpc_pin_sync.sv
module wpc_pin_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = pin_i;
      end else begin : g_next
        assign d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= d;
      end
    end
  endgenerate

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/wpc_we_flag.sv
module wpc_we_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wpc_cfg_reg.sv
module wpc_cfg_reg
  import wpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  wpc_cfg_t cfg_i,
  output wpc_cfg_t cfg_o
);
  wpc_cfg_t cfg_q;
  wpc_cfg_t cfg_d;

  always_comb begin
    cfg_d = load_i ? cfg_i : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wpc_zone_check.sv
module wpc_zone_check
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ZONE_W-1:0] zone_i,
  output logic              prot_o
);
  localparam int TOP = ADDR_W - 1;
  logic [1:0] quarter;

  assign quarter = addr_i[TOP -: 2];

  always_comb begin
    case (wpc_zone_e'(zone_i))
      ZONE_NONE:    prot_o = 1'b0;
      ZONE_QUARTER: prot_o = (quarter == 2'b11);
      ZONE_HALF:    prot_o = quarter[1];
      ZONE_ALL:     prot_o = 1'b1;
      default:      prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              we_set_i,
  input  logic              we_clr_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              cfg_wr_i,
  input  logic [STAT_W-1:0] cfg_data_i,
  output logic              arr_grant_o,
  output logic              cfg_grant_o,
  output logic              hw_locked_o,
  output logic [STAT_W-1:0] status_o
);
  logic     rst_q;
  logic     wp_n_q;
  logic     we_flag;
  logic     zone_prot;
  logic     flag_clr;
  wpc_cfg_t cfg_cur;
  wpc_cfg_t cfg_new;

  wpc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_q_n (rst_q)
  );

  wpc_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pin (
    .clk   (clk),
    .rst_n (rst_q),
    .pin_i (wp_n_i),
    .pin_o (wp_n_q)
  );

  wpc_zone_check #(.ADDR_W(ADDR_W)) u_zone (
    .addr_i (arr_addr_i),
    .zone_i (cfg_cur.zone),
    .prot_o (zone_prot)
  );

  always_comb begin
    hw_locked_o = cfg_cur.lock & ~wp_n_q;
    arr_grant_o = arr_wr_i & we_flag & ~zone_prot;
    cfg_grant_o = cfg_wr_i & we_flag & ~hw_locked_o;
    flag_clr    = we_clr_i | arr_grant_o | cfg_grant_o;
    cfg_new.lock = cfg_data_i[LOCK_BIT];
    cfg_new.zone = cfg_data_i[ZONE_LSB +: ZONE_W];
  end

  wpc_we_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_i  (we_set_i),
    .clr_i  (flag_clr),
    .flag_o (we_flag)
  );

  wpc_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_q),
    .load_i (cfg_grant_o),
    .cfg_i  (cfg_new),
    .cfg_o  (cfg_cur)
  );

  always_comb begin
    status_o                        = '0;
    status_o[BUSY_BIT]              = busy_i;
    status_o[WE_BIT]                = we_flag;
    status_o[ZONE_LSB +: ZONE_W]    = cfg_cur.zone;
    status_o[LOCK_BIT]              = cfg_cur.lock;
  end
endmodule

// File: rtl/wpc_ctrl_chk.sv
module wpc_ctrl_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       we_set_i,
  input logic       we_clr_i,
  input logic       arr_wr_i,
  input logic       cfg_wr_i,
  input logic [7:0] cfg_data_i,
  input logic       arr_grant_o,
  input logic       cfg_grant_o,
  input logic       hw_locked_o,
  input logic [7:0] status_o
);
  assert_set_flag_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (we_set_i && !we_clr_i && !arr_grant_o && !cfg_grant_o) |=> status_o[1]);

  assert_grant_clears_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (arr_grant_o || cfg_grant_o || we_clr_i) |=> !status_o[1]);

  assert_grant_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (arr_grant_o || cfg_grant_o) |-> status_o[1]);

  assert_full_zone_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (status_o[3:2] == 2'b11) |-> !arr_grant_o);

  assert_cfg_load_R5: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_grant_o |=> (status_o[7] == $past(cfg_data_i[7])) &&
                    (status_o[3:2] == $past(cfg_data_i[3:2])));

  assert_hw_lock_R6: assert property (@(posedge clk) disable iff (!rst_q)
    hw_locked_o |-> !cfg_grant_o);

  assert_refusal_keeps_R8: assert property (@(posedge clk) disable iff (!rst_q)
    ((arr_wr_i || cfg_wr_i) && !arr_grant_o && !cfg_grant_o && !we_clr_i && !we_set_i)
      |=> $stable(status_o[7:1]));
endmodule

bind wpc_ctrl wpc_ctrl_chk u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .we_set_i    (we_set_i),
  .we_clr_i    (we_clr_i),
  .arr_wr_i    (arr_wr_i),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_data_i  (cfg_data_i),
  .arr_grant_o (arr_grant_o),
  .cfg_grant_o (cfg_grant_o),
  .hw_locked_o (hw_locked_o),
  .status_o    (status_o)
);

// File: tb/wpc_ctrl_test.sv
module wpc_ctrl_test;
  logic        clk;
  logic        arst_n;
  logic        wp_n_i;
  logic        busy_i;
  logic        we_set_i;
  logic        we_clr_i;
  logic        arr_wr_i;
  logic [14:0] arr_addr_i;
  logic        cfg_wr_i;
  logic [7:0]  cfg_data_i;
  logic        arr_grant_o;
  logic        cfg_grant_o;
  logic        hw_locked_o;
  logic [7:0]  status_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_we = 0, m_zone = 0, m_lock = 0;
  int m_s1 = 0, m_s2 = 0, m_r1 = 0, m_r2 = 0;

  wpc_ctrl uut (
    .clk(clk), .arst_n(arst_n), .wp_n_i(wp_n_i), .busy_i(busy_i),
    .we_set_i(we_set_i), .we_clr_i(we_clr_i), .arr_wr_i(arr_wr_i),
    .arr_addr_i(arr_addr_i), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .arr_grant_o(arr_grant_o), .cfg_grant_o(cfg_grant_o),
    .hw_locked_o(hw_locked_o), .status_o(status_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic int in_zone(int addr, int zone);
    if (zone == 1) return (addr >= 24576) ? 1 : 0;
    if (zone == 2) return (addr >= 16384) ? 1 : 0;
    if (zone == 3) return 1;
    return 0;
  endfunction

  task automatic clear_model();
    m_we = 0; m_zone = 0; m_lock = 0;
    m_s1 = 0; m_s2 = 0; m_r1 = 0; m_r2 = 0;
  endtask

  task automatic step(input string req);
    int e_ag, e_cg, e_hl, e_st;
    #1;
    if (!arst_n) clear_model();
    e_hl = (m_lock != 0 && m_s2 == 0) ? 1 : 0;
    e_ag = (arr_wr_i && m_we != 0 && in_zone(int'(arr_addr_i), m_zone) == 0) ? 1 : 0;
    e_cg = (cfg_wr_i && m_we != 0 && e_hl == 0) ? 1 : 0;
    e_st = m_lock * 128 + m_zone * 4 + m_we * 2 + int'(busy_i);
    checks++;
    if (int'(arr_grant_o) != e_ag || int'(cfg_grant_o) != e_cg ||
        int'(hw_locked_o) != e_hl || int'(status_o) != e_st) begin
      errors++;
      $display("FAIL %s: ag=%0d cg=%0d hl=%0d st=%02h expected ag=%0d cg=%0d hl=%0d st=%02h",
               req, arr_grant_o, cfg_grant_o, hw_locked_o, status_o, e_ag, e_cg, e_hl, e_st);
    end
    @(posedge clk);
    if (!arst_n) begin
      clear_model();
    end else begin
      if (m_r2 != 0) begin
        if (we_clr_i || e_ag != 0 || e_cg != 0) m_we = 0;
        else if (we_set_i) m_we = 1;
        if (e_cg != 0) begin
          m_lock = int'(cfg_data_i[7]);
          m_zone = int'(cfg_data_i[3:2]);
        end
        m_s2 = m_s1;
        m_s1 = int'(wp_n_i);
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
    @(negedge clk);
    we_set_i = 0; we_clr_i = 0; arr_wr_i = 0; cfg_wr_i = 0;
  endtask

  task automatic arr_write(input logic [14:0] a, input string req);
    arr_wr_i = 1; arr_addr_i = a; step(req);
  endtask

  task automatic cfg_write(input logic [7:0] d, input string req);
    cfg_wr_i = 1; cfg_data_i = d; step(req);
  endtask

  task automatic set_we(input string req);
    we_set_i = 1; step(req);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 0; wp_n_i = 1; busy_i = 0; we_set_i = 0; we_clr_i = 0;
    arr_wr_i = 0; arr_addr_i = '0; cfg_wr_i = 0; cfg_data_i = '0;
    @(negedge clk);
    step("R10 reset");
    step("R10 reset");
    arst_n = 1;
    for (int i = 0; i < 4; i++) step("R10 release");

    arr_write(15'h0000, "R8 refused without flag");
    step("R8 flag still clear");
    set_we("R1 set");
    step("R1 flag readback");
    arr_write(15'h0100, "R3 granted write");
    step("R2 cleared by write");
    set_we("R1 set");
    we_clr_i = 1; step("R2 clear strobe");
    step("R2 flag cleared");

    set_we("R1 set");
    cfg_write(8'hF6, "R5 load lock and quarter zone");
    step("R9 layout bits 6:4 zero");
    set_we("R1 set");
    arr_write(15'h6000, "R4 quarter protects 0x6000");
    step("R8 flag kept after refusal");
    arr_write(15'h5FFF, "R4 quarter leaves 0x5FFF");
    set_we("R1 set");
    cfg_write(8'h08, "R7 pin high lets config write");
    set_we("R1 set");
    arr_write(15'h4000, "R4 half protects 0x4000");
    arr_write(15'h3FFF, "R4 half leaves 0x3FFF");

    set_we("R1 set");
    cfg_write(8'h88, "R5 lock set with half zone");
    wp_n_i = 0;
    step("R6 pin low edge 1");
    step("R6 pin low edge 2");
    step("R6 lock visible");
    set_we("R1 set");
    cfg_write(8'h00, "R6 locked config refused");
    step("R8 state kept under lock");
    wp_n_i = 1;
    step("R6 pin high edge 1");
    step("R6 pin high edge 2");
    cfg_write(8'h0C, "R7 unlocked, full zone");
    set_we("R1 set");
    arr_write(15'h0000, "R4 full zone protects 0");
    step("R8 flag kept");

    cfg_write(8'h00, "R5 open zone");
    set_we("R1 set");
    we_set_i = 1; we_clr_i = 1; step("R11 clear beats set");
    step("R11 flag clear");
    set_we("R1 set");
    we_set_i = 1; arr_wr_i = 1; arr_addr_i = 15'h7FFF; step("R11 grant beats set");
    step("R11 flag clear");
    set_we("R1 set");
    arr_wr_i = 1; arr_addr_i = 15'h7000; cfg_wr_i = 1; cfg_data_i = 8'h0C;
    step("R11 both judged on old state");
    step("R11 full zone loaded, flag clear");

    busy_i = 1; step("R9 busy bit");
    busy_i = 0; step("R9 busy bit low");

    set_we("R1 set");
    arst_n = 0; step("R10 async clear");
    arst_n = 1;
    we_set_i = 1; step("R10 set ignored while synchronizing");
    step("R10 flag clear");
    set_we("R1 set after sync");
    step("R1 flag readback");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule